// File: doc/BRIEF.md
# Battery-Gated Wakeup Sequencer

This block wakes a sleeping processor when an active-low carrier-detect pin is pulled low. On that event it raises a power-on indication for a fixed number of clock cycles and samples a battery-permit input on the last cycle of that window. If the battery permits it, the block releases peripheral reset, fires a one-cycle cold-start pulse and holds a run state until an external shutdown request arrives. If the battery does not permit it, the block records a sticky battery-inhibit flag and drops straight back to the off state with reset still applied.

Both asynchronous inputs pass through two-flop synchronizers. Detect-pin activity is frozen out while the power-on window is open. The block remembers the pin level at window entry. If the level at window exit differs, that change is taken up in the first cycle after the window. If the level is the same, any toggling inside the window is lost. A single 8-bit status register shows the sticky battery-inhibit flag and the live synchronized pin level.

Top module: `wake_seq_top`

## Requirements
- R1: After reset, power_on, periph_rst_n, cold_start and cpu_run are all 0, and reg_rdata reads 8'h02 (flag clear, idle pin high).
- R2: In the off state, a high-to-low change on cd_n_in raises power_on at the third rising clock edge after the pin change (two synchronizer stages plus the state register).
- R3: power_on stays high for exactly WIN_CYCLES consecutive clock cycles (default 16).
- R4: If batt_ok_in is 1 at the last window cycle, periph_rst_n goes to 1 in the cycle power_on drops, cold_start is 1 for exactly the following cycle, and cpu_run is 1 from the cycle after that.
- R5: If batt_ok_in is 0 at the last window cycle, reg_rdata bit 0 becomes 1 in the cycle power_on drops, the block returns to off, periph_rst_n stays 0 and cold_start never pulses.
- R6: reg_rdata bit 0 is sticky. A write (reg_wr=1) with reg_wdata bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and a set from a failed window wins over a clearing write in the same cycle.
- R7: reg_rdata bit 1 is the synchronized cd_n_in level (1 = pin high), following the pin after two clock edges. Bits 7:2 read 0.
- R8: Changes on cd_n_in while power_on is high are ignored. A pin pulse that starts and ends inside the window starts no new wakeup.
- R9: Only a high-to-low change wakes the block. A pin held low across the window causes no second wakeup. A pin that is high at window exit is taken as the new reference level, so its next fall wakes the block.
- R10: In the run state, shutdown_req returns the block to off on the next edge (cpu_run and periph_rst_n go to 0), and detect-pin falls do not raise power_on.
- R11: power_on, cold_start and cpu_run are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd_n_in | input | 1 | Asynchronous active-low carrier-detect pin |
| batt_ok_in | input | 1 | Asynchronous battery permit (1 = boot allowed) |
| shutdown_req | input | 1 | Synchronous request to leave the run state |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data (bit 0 = 0 clears the flag) |
| reg_rdata | output | 8 | Status: bit 0 battery-inhibit flag, bit 1 synchronized pin level |
| power_on | output | 1 | Activation-in-progress indication |
| periph_rst_n | output | 1 | Peripheral reset, 1 = released |
| cold_start | output | 1 | One-cycle start pulse for the core cold reset |
| cpu_run | output | 1 | Core running |

## Verification
Every cycle, the assertions check the local sequencing rules. These are: entry into the window on a recognized fall, the frozen reference during the window, the single-cycle start pulse following reset release, reset kept on a failed window, shutdown from run, exclusivity of the three state outputs, and stickiness of the flag. Some behaviours can only be shown by the bench's scenarios, because they span many cycles from the pin to the outputs. These are the exact latency from pin to power_on, the window length seen at the port, the loss of a pulse that lies wholly inside the window, the pickup of a level difference at window exit, and set-over-clear priority at the exact cycle the window closes.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WIN   = 3'd1,
        ST_REL   = 3'd2,
        ST_START = 3'd3,
        ST_RUN   = 3'd4
    } wake_state_e;

    localparam int STAT_W    = 8;
    localparam int STAT_FLAG = 0;
    localparam int STAT_PIN  = 1;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign dout[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_pkg::*;
#(
    parameter int WIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_s,
    input  logic batt_s,
    input  logic shutdown_req,
    output logic power_on,
    output logic periph_rst_n,
    output logic cold_start,
    output logic cpu_run,
    output logic batt_fail
);
    localparam int             CW   = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0]  LAST = CW'(WIN_CYCLES - 1);

    typedef struct packed {
        wake_state_e   state;
        logic [CW-1:0] cnt;
        logic          cd_ref;
    } fsm_t;

    fsm_t q, d;
    logic in_win, fall;

    always_comb begin
        d         = q;
        batt_fail = 1'b0;
        in_win    = (q.state == ST_WIN);
        fall      = q.cd_ref && !cd_s;
        if (!in_win) d.cd_ref = cd_s;
        case (q.state)
            ST_OFF: begin
                if (fall) begin
                    d.state = ST_WIN;
                    d.cnt   = '0;
                end
            end
            ST_WIN: begin
                if (q.cnt == LAST) begin
                    if (batt_s) begin
                        d.state = ST_REL;
                    end else begin
                        d.state   = ST_OFF;
                        batt_fail = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REL:   d.state = ST_START;
            ST_START: d.state = ST_RUN;
            ST_RUN:   if (shutdown_req) d.state = ST_OFF;
            default:  d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_OFF;
            q.cnt    <= '0;
            q.cd_ref <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign power_on     = (q.state == ST_WIN);
    assign cold_start   = (q.state == ST_START);
    assign cpu_run      = (q.state == ST_RUN);
    assign periph_rst_n = (q.state == ST_REL) || (q.state == ST_START) || (q.state == ST_RUN);

    // R2
    wake_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OFF && !cd_s && q.cd_ref) |=> power_on);

    // R8
    win_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WIN && q.cnt != LAST) |=> (power_on && $stable(q.cd_ref)));

    // R4
    cold_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_start |=> (!cold_start && cpu_run));

    // R4
    rel_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_start |-> (periph_rst_n && $past(periph_rst_n)));

    // R5
    fail_keep_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batt_fail |=> (!periph_rst_n && !power_on && !cold_start));

    // R10
    run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && shutdown_req) |=> (!cpu_run && !periph_rst_n));

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({power_on, cold_start, cpu_run}));
endmodule

// File: rtl/wake_status.sv
module wake_status
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_flag,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              pin_s,
    output logic [STAT_W-1:0] rdata
);
    typedef struct packed {
        logic flag;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (set_flag)                   d.flag = 1'b1;
        else if (wr && !wdata[STAT_FLAG]) d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.flag <= 1'b0;
        else        q      <= d;
    end

    always_comb begin
        rdata            = '0;
        rdata[STAT_FLAG] = q.flag;
        rdata[STAT_PIN]  = pin_s;
    end

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[STAT_FLAG] && !(wr && !wdata[STAT_FLAG])) |=> rdata[STAT_FLAG]);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> rdata[STAT_FLAG]);
endmodule

// File: rtl/wake_seq_top.sv
module wake_seq_top
    import wake_pkg::*;
#(
    parameter int WIN_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cd_n_in,
    input  logic              batt_ok_in,
    input  logic              shutdown_req,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              power_on,
    output logic              periph_rst_n,
    output logic              cold_start,
    output logic              cpu_run
);
    logic cd_s, batt_s, batt_fail;

    wake_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cd_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cd_n_in),
        .dout (cd_s)
    );

    wake_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_batt_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (batt_ok_in),
        .dout (batt_s)
    );

    wake_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cd_s        (cd_s),
        .batt_s      (batt_s),
        .shutdown_req(shutdown_req),
        .power_on    (power_on),
        .periph_rst_n(periph_rst_n),
        .cold_start  (cold_start),
        .cpu_run     (cpu_run),
        .batt_fail   (batt_fail)
    );

    wake_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_flag(batt_fail),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .pin_s   (cd_s),
        .rdata   (reg_rdata)
    );
endmodule

// File: tb/tb_wake_seq_top.sv
module tb_wake_seq_top;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cd_n_in = 1'b1;
    logic       batt_ok_in = 1'b0;
    logic       shutdown_req = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       power_on, periph_rst_n, cold_start, cpu_run;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wake_seq_top #(.WIN_CYCLES(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .cd_n_in(cd_n_in), .batt_ok_in(batt_ok_in),
        .shutdown_req(shutdown_req), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .power_on(power_on), .periph_rst_n(periph_rst_n),
        .cold_start(cold_start), .cpu_run(cpu_run)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_high();
        cd_n_in = 1'b1;
        tick(5);
    endtask

    task automatic reg_write(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        tick(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    // pull the pin low and check power_on latency; leaves the bench at the first window cycle
    task automatic open_window(input string req);
        cd_n_in = 1'b0;
        tick(2);
        check({req, " power_on before 3rd edge"}, power_on, 0);
        tick(1);
        check({req, " power_on at 3rd edge"}, power_on, 1);
    endtask

    // mode 0 none, 1 pulse inside window, 2 pin rises and stays, 3 clearing write on last cycle
    task automatic run_window(input int mode);
        int hi = 0;
        for (int i = 1; i <= WIN; i++) begin
            hi += int'(power_on);
            if (mode == 1 && i == 4) cd_n_in = 1'b1;
            if (mode == 1 && i == 7) cd_n_in = 1'b0;
            if (mode == 2 && i == 5) cd_n_in = 1'b1;
            if (mode == 3 && i == WIN) begin reg_wr = 1'b1; reg_wdata = 8'h00; end
            if (i < WIN) tick(1);
        end
        tick(1);
        reg_wr = 1'b0;
        check("R3 window high cycles", hi, WIN);
        check("R3 power_on low after window", power_on, 0);
    endtask

    task automatic t_reset();
        check("R1 power_on", power_on, 0);
        check("R1 periph_rst_n", periph_rst_n, 0);
        check("R1 cold_start", cold_start, 0);
        check("R1 cpu_run", cpu_run, 0);
        check("R1 reg_rdata", reg_rdata, 8'h02);
    endtask

    task automatic t_boot();
        batt_ok_in = 1'b1;
        settle_high();
        open_window("R2 boot");
        run_window(0);
        check("R4 reset released at window end", periph_rst_n, 1);
        check("R4 no start yet", cold_start, 0);
        tick(1);
        check("R4 start pulse", cold_start, 1);
        tick(1);
        check("R4 start pulse ends", cold_start, 0);
        check("R4 run", cpu_run, 1);
        check("R7 pin low readback", reg_rdata, 8'h00);
        cd_n_in = 1'b1;
        tick(1);
        check("R7 pin one edge later", reg_rdata[1], 0);
        tick(1);
        check("R7 pin two edges later", reg_rdata[1], 1);
        cd_n_in = 1'b0;
        tick(5);
        check("R10 no wake in run", power_on, 0);
        check("R10 still run", cpu_run, 1);
        cd_n_in = 1'b1;
        tick(4);
        shutdown_req = 1'b1;
        tick(1);
        shutdown_req = 1'b0;
        check("R10 run cleared", cpu_run, 0);
        check("R10 reset applied", periph_rst_n, 0);
    endtask

    task automatic t_batt_low();
        int extra = 0;
        batt_ok_in = 1'b0;
        settle_high();
        open_window("R2 low batt");
        run_window(0);
        check("R5 flag set", reg_rdata[0], 1);
        check("R5 reset kept", periph_rst_n, 0);
        for (int i = 0; i < 12; i++) begin
            extra += int'(cold_start) + int'(power_on) + int'(periph_rst_n);
            tick(1);
        end
        check("R9 held-low pin no rewake / R5 no start", extra, 0);
        reg_write(8'h01);
        check("R6 write one keeps flag", reg_rdata[0], 1);
        reg_write(8'hFE);
        check("R6 write zero clears flag", reg_rdata[0], 0);
        check("R7 upper bits zero", int'(reg_rdata & 8'hFC), 0);
    endtask

    task automatic t_pulse_in_window();
        int seen = 0;
        batt_ok_in = 1'b0;
        settle_high();
        open_window("R2 pulse");
        run_window(1);
        for (int i = 0; i < 20; i++) begin
            seen += int'(power_on);
            tick(1);
        end
        check("R8 pulse inside window lost", seen, 0);
        reg_write(8'h00);
    endtask

    task automatic t_set_priority();
        batt_ok_in = 1'b0;
        settle_high();
        open_window("R2 priority");
        run_window(3);
        check("R6 set wins over clear", reg_rdata[0], 1);
        reg_write(8'h00);
        check("R6 clear after priority", reg_rdata[0], 0);
    endtask

    task automatic t_exit_diff();
        int seen = 0;
        batt_ok_in = 1'b0;
        settle_high();
        open_window("R2 exit");
        run_window(2);
        for (int i = 0; i < 6; i++) begin
            seen += int'(power_on);
            tick(1);
        end
        check("R9 rising at exit no wake", seen, 0);
        open_window("R9 fall after exit");
        run_window(0);
        reg_write(8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_boot();
        t_batt_low();
        t_pulse_in_window();
        t_set_priority();
        t_exit_diff();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule